// File: doc/BRIEF.md
# Correlated Double Sampling Frame Engine

This block cleans the raw pixel stream of one sensor sector by correlated double sampling. Samples arrive in raster order, one per pixel clock. For each one the engine fetches the value that the same pixel gave on the previous frame, subtracts it, and writes the new sample back over it. The external memory therefore always holds a rolling copy of the most recent full frame. The difference is clamped into an 8-bit unsigned value. A per-pixel hot mask forces the result to zero, so noisy pixels drop out of the data that follows.

The memory port issues one read and one write per pixel tick, through separate read and write addresses. The memory returns read data one clock after the read. The mask bit of each pixel is kept in the same memory word as its stored sample, so the mask needs no storage of its own. A mask write waits in a one-entry holding register until the scan next reaches that pixel. The frame geometry is set by parameters, so a reduced raster can be used for simulation. After reset the engine runs one priming frame with its outputs withheld.

Top module: `cds_frame_engine`

## Requirements
- R1: Every sample with `in_valid` high is accepted in that clock, with no stall. Once the reference is primed, each accepted sample produces exactly one `out_valid` pulse two clocks later, and the outputs keep the input order.
- R2: A sample accepted in clock n reads the memory at its pixel address in clock n. In clock n+1 it writes the word {mask bit at bit IN_W, sample at bits IN_W-1:0} back to the same address.
- R3: The pixel address is 0 when `in_sof` is high with the sample. Otherwise it is the previous address plus one, and it wraps from ROW_PIX*COLS-1 to 0. `out_idx` reports the address of each output.
- R4: `out_pix` is the new sample minus the stored sample for that pixel, clamped to 0..255. A negative or zero difference gives 0, and a difference above 255 gives 255.
- R5: After reset, no output is valid until a sample has been written to the last address, ROW_PIX*COLS-1. The first sample after that write gives a valid output.
- R6: A write on `mask_we` with `mask_addr` and `mask_set` takes effect the next time the scan reaches that pixel, and from then on. A masked pixel still gives `out_valid` with `out_pix` = 0, and clearing the bit restores the normal output. Only the newest unapplied mask write is kept.
- R7: During and right after reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this clock |
| in_sof | input | 1 | Sample is pixel 0 of a frame |
| in_sample | input | IN_W | Raw ADC sample |
| mask_we | input | 1 | Hot-mask write strobe |
| mask_addr | input | AW | Pixel address for the mask write |
| mask_set | input | 1 | 1 masks the pixel, 0 unmasks it |
| sram_re | output | 1 | Memory read enable |
| sram_raddr | output | AW | Memory read address |
| sram_rdata | input | IN_W+1 | Memory read data, one clock after the read |
| sram_we | output | 1 | Memory write enable |
| sram_waddr | output | AW | Memory write address |
| sram_wdata | output | IN_W+1 | Memory write data {mask, sample} |
| out_valid | output | 1 | Corrected pixel present |
| out_pix | output | 8 | Corrected, clamped pixel value |
| out_idx | output | AW | Pixel address of the output |

## Verification
A wrong scan address shows up in `out_idx` in the very next output. It also shows up one frame later, when the differences are taken against the wrong stored samples. A fault in the write-back or in the mask merge only becomes visible when the same pixel comes round again, so the stimulus runs many full frames of a small raster. It also checks mask writes one frame after they are issued. Clamp faults appear at once on the directed pixels whose differences sit at and beyond the ends of the 0..255 range.

// File: rtl/cds_pkg.sv
package cds_pkg;
   localparam int OUT_W = 8;
   typedef logic [OUT_W-1:0] pix_t;
endpackage

// File: rtl/cds_scan_addr.sv
module cds_scan_addr #(
   parameter int FRAME = 204800,
   parameter int AW    = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sof,
   output logic [AW-1:0] cur_addr
);
   localparam logic [AW-1:0] LAST = AW'(FRAME - 1);

   logic [AW-1:0] nxt_addr;

   assign cur_addr = in_sof ? '0 : nxt_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         nxt_addr <= '0;
      else if (in_valid)
         nxt_addr <= (cur_addr == LAST) ? '0 : cur_addr + 1'b1;
   end

   assert_addr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cur_addr == LAST) |=> (nxt_addr == '0));
   assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cur_addr <= LAST);
endmodule

// File: rtl/cds_mask_pend.sv
module cds_mask_pend #(
   parameter int AW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mask_we,
   input  logic [AW-1:0] mask_addr,
   input  logic          mask_set,
   input  logic          probe_valid,
   input  logic [AW-1:0] probe_addr,
   input  logic          stored_bit,
   output logic          eff_bit
);
   logic          pend_valid;
   logic [AW-1:0] pend_addr;
   logic          pend_bit;
   logic          hit;

   assign hit     = pend_valid && probe_valid && (pend_addr == probe_addr);
   assign eff_bit = hit ? pend_bit : stored_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_addr  <= '0;
         pend_bit   <= 1'b0;
      end else if (mask_we) begin
         pend_valid <= 1'b1;
         pend_addr  <= mask_addr;
         pend_bit   <= mask_set;
      end else if (hit) begin
         pend_valid <= 1'b0;
      end
   end

   assert_pend_consumed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !mask_we) |=> !pend_valid);
endmodule

// File: rtl/cds_diff_clamp.sv
module cds_diff_clamp #(
   parameter int IN_W  = 10,
   parameter int OUT_W = 8
) (
   input  logic [IN_W-1:0]  cur,
   input  logic [IN_W-1:0]  prev,
   output logic [OUT_W-1:0] res
);
   logic [IN_W:0] diff;

   assign diff = {1'b0, cur} - {1'b0, prev};

   if (IN_W > OUT_W) begin : g_wide
      always_comb begin
         if (diff[IN_W])
            res = '0;
         else if (|diff[IN_W-1:OUT_W])
            res = '1;
         else
            res = diff[OUT_W-1:0];
      end
   end else begin : g_narrow
      always_comb begin
         if (diff[IN_W])
            res = '0;
         else
            res = OUT_W'(diff[IN_W-1:0]);
      end
   end
endmodule

// File: rtl/cds_frame_engine.sv
module cds_frame_engine
   import cds_pkg::*;
#(
   parameter int ROW_PIX = 640,
   parameter int COLS    = 320,
   parameter int IN_W    = 10,
   localparam int FRAME  = ROW_PIX * COLS,
   localparam int AW     = $clog2(FRAME),
   localparam int DW     = IN_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic [IN_W-1:0]  in_sample,
   input  logic             mask_we,
   input  logic [AW-1:0]    mask_addr,
   input  logic             mask_set,
   output logic             sram_re,
   output logic [AW-1:0]    sram_raddr,
   input  logic [DW-1:0]    sram_rdata,
   output logic             sram_we,
   output logic [AW-1:0]    sram_waddr,
   output logic [DW-1:0]    sram_wdata,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_pix,
   output logic [AW-1:0]    out_idx
);
   localparam logic [AW-1:0] LAST = AW'(FRAME - 1);

   if (FRAME < 3) begin : g_bad_frame
      $error("cds_frame_engine: raster must hold at least 3 pixels");
   end
   if (IN_W < OUT_W) begin : g_bad_width
      $error("cds_frame_engine: sample width below output width");
   end

   logic [AW-1:0]   cur_addr;
   logic            s1_valid;
   logic [AW-1:0]   s1_addr;
   logic [IN_W-1:0] s1_sample;
   logic            ref_ready;
   logic            eff_mask;
   pix_t            clamped;
   logic [IN_W-1:0] prev_sample;

   cds_scan_addr #(.FRAME(FRAME), .AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .cur_addr(cur_addr)
   );

   assign sram_re    = in_valid;
   assign sram_raddr = cur_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_addr   <= '0;
         s1_sample <= '0;
      end else begin
         s1_valid  <= in_valid;
         s1_addr   <= cur_addr;
         s1_sample <= in_sample;
      end
   end

   assign prev_sample = sram_rdata[IN_W-1:0];

   cds_mask_pend #(.AW(AW)) u_mask (
      .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_addr(mask_addr),
      .mask_set(mask_set), .probe_valid(s1_valid), .probe_addr(s1_addr),
      .stored_bit(sram_rdata[IN_W]), .eff_bit(eff_mask)
   );

   cds_diff_clamp #(.IN_W(IN_W), .OUT_W(OUT_W)) u_clamp (
      .cur(s1_sample), .prev(prev_sample), .res(clamped)
   );

   assign sram_we    = s1_valid;
   assign sram_waddr = s1_addr;
   assign sram_wdata = {eff_mask, s1_sample};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_ready <= 1'b0;
         out_valid <= 1'b0;
         out_pix   <= '0;
         out_idx   <= '0;
      end else begin
         if (s1_valid && s1_addr == LAST)
            ref_ready <= 1'b1;
         out_valid <= s1_valid && ref_ready;
         out_pix   <= eff_mask ? '0 : clamped;
         out_idx   <= s1_addr;
      end
   end

   assert_wb_same_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sram_re |=> (sram_we && sram_waddr == $past(sram_raddr)));
   assert_wb_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sram_re |=> (sram_wdata[IN_W-1:0] == $past(in_sample)));
   assert_no_early_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(ref_ready));
   assert_clamp_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && ref_ready && s1_sample <= prev_sample) |=> (out_pix == '0));
   assert_mask_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && eff_mask) |=> (out_pix == '0));
   assert_one_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && ref_ready) |=> out_valid);
endmodule

// File: tb/sim_cds_frame_engine.sv
module sim_cds_frame_engine;
   localparam int CLK_PERIOD = 20;
   localparam int ROW_PIX = 8;
   localparam int COLS    = 4;
   localparam int IN_W    = 10;
   localparam int FRAME   = ROW_PIX * COLS;
   localparam int AW      = $clog2(FRAME);
   localparam int DW      = IN_W + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_sof = 1'b0;
   logic [IN_W-1:0] in_sample = '0;
   logic mask_we = 1'b0, mask_set = 1'b0;
   logic [AW-1:0] mask_addr = '0;
   logic sram_re, sram_we;
   logic [AW-1:0] sram_raddr, sram_waddr;
   logic [DW-1:0] sram_rdata, sram_wdata;
   logic out_valid;
   logic [7:0] out_pix;
   logic [AW-1:0] out_idx;

   always #(CLK_PERIOD/2) clk = ~clk;

   cds_frame_engine #(.ROW_PIX(ROW_PIX), .COLS(COLS), .IN_W(IN_W)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_sample(in_sample), .mask_we(mask_we), .mask_addr(mask_addr),
      .mask_set(mask_set), .sram_re(sram_re), .sram_raddr(sram_raddr),
      .sram_rdata(sram_rdata), .sram_we(sram_we), .sram_waddr(sram_waddr),
      .sram_wdata(sram_wdata), .out_valid(out_valid), .out_pix(out_pix),
      .out_idx(out_idx)
   );

   logic [DW-1:0] mem [FRAME];
   always_ff @(posedge clk) begin
      if (sram_re) sram_rdata <= mem[sram_raddr];
      if (sram_we) mem[sram_waddr] <= sram_wdata;
   end

   int checks = 0, errors = 0, tick_no = 0, m_addr = 0;
   bit model_ready = 0, done = 0;
   int ref_prev [FRAME];
   bit ref_mask [FRAME];
   int exp_pix [$];
   int exp_idx [$];
   int exp_tick [$];
   bit exp_msk [$];

   function automatic int clamp_diff(int cur, int prev);  // R4
      int d = cur - prev;
      if (d < 0) return 0;
      if (d > 255) return 255;
      return d;
   endfunction

   task automatic check(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic tick(bit v, bit sof, int s, bit mwe = 0, int maddr = 0, bit mset = 0);
      @(negedge clk);
      tick_no++;
      if (out_valid) begin
         if (exp_pix.size() == 0) check(0, "R5 unexpected output", 1, 0);
         else begin
            int ep = exp_pix.pop_front();
            int ei = exp_idx.pop_front();
            int et = exp_tick.pop_front();
            bit em = exp_msk.pop_front();
            check(out_pix == 8'(ep), em ? "R6 masked pix" : "R4 pix", out_pix, ep);
            check(out_idx == AW'(ei), "R3 idx", out_idx, ei);
            check(tick_no - et == 2, "R1 latency", tick_no - et, 2);
         end
      end
      in_valid  = v;
      in_sof    = sof;
      in_sample = IN_W'(s);
      mask_we   = mwe;
      mask_addr = AW'(maddr);
      mask_set  = mset;
      if (mwe) ref_mask[maddr] = mset;
      if (v) begin
         int a = sof ? 0 : m_addr;
         if (model_ready) begin
            exp_pix.push_back(ref_mask[a] ? 0 : clamp_diff(s, ref_prev[a]));
            exp_idx.push_back(a);
            exp_tick.push_back(tick_no);
            exp_msk.push_back(ref_mask[a]);
         end
         ref_prev[a] = s;
         if (a == FRAME - 1) model_ready = 1;
         m_addr = (a == FRAME - 1) ? 0 : a + 1;
      end
   endtask

   task automatic rand_frame(bit sof, int gap_pct);
      for (int p = 0; p < FRAME; p++) begin
         while (int'($urandom_range(99)) < gap_pct) tick(0, 0, 0);
         tick(1, sof && p == 0, int'($urandom_range(1023)));
      end
   endtask

   task automatic drain();
      for (int i = 0; i < 4; i++) tick(0, 0, 0);
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < FRAME; i++) begin ref_prev[i] = 0; ref_mask[i] = 0; end
      #(CLK_PERIOD * 3);
      @(negedge clk);
      check(out_valid == 1'b0, "R7 reset out_valid", out_valid, 0);
      rst_n = 1'b1;
      // R5 priming frame: no outputs expected
      for (int p = 0; p < FRAME; p++) tick(1, p == 0, 500 + p);
      drain();
      check(checks == 1, "R5 no output in priming frame", checks - 1, 0);
      // R4 directed clamp corners against stored 500+p
      tick(1, 1, 0);      // below -> 0
      tick(1, 0, 1023);   // 522 -> 255
      tick(1, 0, 757);    // exactly 255
      tick(1, 0, 759);    // 256 -> 255
      tick(1, 0, 504);    // zero
      tick(1, 0, 505 + 17); // 17
      for (int p = 6; p < FRAME; p++) tick(1, 0, int'($urandom_range(1023)));
      // R3 wrap without sof, with gaps
      rand_frame(0, 20);
      // R6 mask pixel 5 during a gap, then a full frame
      tick(0, 0, 0, 1, 5, 1);
      rand_frame(0, 10);
      rand_frame(0, 0);
      tick(0, 0, 0, 1, 5, 0);
      rand_frame(0, 10);
      rand_frame(0, 0);
      // R3 mid-frame restart
      for (int p = 0; p < FRAME / 2; p++) tick(1, 0, int'($urandom_range(1023)));
      rand_frame(1, 15);
      // random frames with occasional mask writes
      for (int f = 0; f < 20; f++) begin
         if (f % 3 == 0)
            tick(0, 0, 0, 1, int'($urandom_range(FRAME - 1)), 1'($urandom_range(1)));
         rand_frame(f % 4 == 1, 25);
      end
      drain();
      check(exp_pix.size() == 0, "R1 outputs missing", exp_pix.size(), 0);
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule